// File: doc/BRIEF.md
# Vectored Interrupt Control Unit

This unit sits beside a small 8-bit processor core. It gathers three interrupt causes and decides, at instruction boundaries, when the core must divert to a single service entry point. The causes are an edge on an external pin, a one-cycle event pulse from a timer, and a non-maskable trap that the core raises when it executes the all-zero opcode. The unit holds a global enable, one enable per maskable cause, the pin edge polarity and two sticky pending flags. Software reads and rewrites all six as one small control word. Software has to inspect the pending flags to decide which cause to serve, because hardware does not prioritise between them.

Once the unit accepts a request, it runs a fixed entry sequence on its own:
- it stores the 15-bit program counter as two bytes through a byte-wide memory write port;
- it lowers the stack pointer by two;
- it loads the fixed service address into the program counter.

When the core requests a return, the unit reads the two bytes back, restores the program counter and raises the stack pointer by two. One flavour of return also re-arms the global enable. Each clock cycle of the unit is one instruction cycle of the core.

Top module: `icu_top`

## Requirements
- R1: After reset the control word `cfgQ` reads 0, `seqBusy` is 0, and `memWe`, `memRe`, `spWe` and `pcWe` are all 0.
- R2: The pin edge is detected after two synchronising flops. The polarity bit 0 selects a rising edge and 1 selects a falling edge. A qualifying edge driven before clock edge k sets the external pending flag at edge k+2 (visible from then on, not before), and it does so even when the global enable is 0.
- R3: Both pending flags stay set until a control-word write clears them. An event that lands in the same cycle as a clearing write leaves the flag set.
- R4: A `timerEvt` pulse sets the timer pending flag at the next clock edge.
- R5: A maskable request starts an entry only when all of the following hold in a cycle where `atBoundary` is 1 and `retReq` is 0: the global enable is 1, and for some source both its enable and its pending flag are 1. The entry starts at the next edge.
- R6: An entry keeps `seqBusy` at 1 for exactly 7 cycles. In cycle 0 the unit writes `pcIn[7:0]` to address SP. In cycle 1 it writes `{1'b0, pcIn[14:8]}` to SP-1. In cycle 2 it drives `spWe` with SP-2. In cycle 6 it drives `pcWe` with 0x00FF. PC and SP are the values sampled at the accepting edge.
- R7: Accepting a maskable request clears the global enable at the accepting edge and leaves the pending flags unchanged.
- R8: A `trapReq` pulse is held internally and is taken at the next boundary whatever the global enable. It wins over a maskable request that is ready in the same cycle, and it leaves the global enable unchanged.
- R9: A `retReq` seen while idle starts a two-cycle return. Cycle 0 reads SP+1 (the high byte). Cycle 1 reads SP+2 (the low byte), drives `pcWe` with the restored 15-bit value, and drives `spWe` with SP+2. The global enable becomes 1 at the end of the return only if `retSetsGie` was 1 when the return was accepted.
- R10: Control word layout, for both write and read: bit 0 global enable, bit 1 external enable, bit 2 timer enable, bit 3 edge polarity, bit 4 external pending, bit 5 timer pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per period |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Write strobe for the control word |
| cfgWdata | input | 6 | Control word value to write |
| cfgQ | output | 6 | Current control word |
| extPin | input | 1 | External interrupt pin, asynchronous |
| timerEvt | input | 1 | One-cycle timer event pulse |
| trapReq | input | 1 | Zero-opcode trap pulse from the core |
| retReq | input | 1 | Return request from the core |
| retSetsGie | input | 1 | Return re-arms the global enable |
| atBoundary | input | 1 | Core is at an instruction boundary |
| pcIn | input | 15 | Current program counter |
| spIn | input | 8 | Current stack pointer |
| memWe | output | 1 | Stack memory write strobe |
| memRe | output | 1 | Stack memory read strobe |
| memAddr | output | 8 | Stack memory address |
| memWdata | output | 8 | Stack memory write data |
| memRdata | input | 8 | Stack memory read data, combinational |
| spWe | output | 1 | Stack pointer load strobe |
| spWdata | output | 8 | New stack pointer |
| pcWe | output | 1 | Program counter load strobe |
| pcWdata | output | 15 | New program counter |
| seqBusy | output | 1 | Entry or return sequence in progress |

## Verification
The pin-to-pending delay is three edges, so the bench expects the pending flag clear two falling-edge samples after it drives the pin and set on the third. A timer pulse or a control-word write shows up at the very next sample. An accepted request makes `seqBusy` high at the first sample after the accepting edge. From that sample on, the bench checks every step of the 7-cycle entry and the 2-cycle return against the cycle index relative to that point. Inputs change just after a falling edge and outputs are read at the next falling edge, so each expected value is tied to an exact count of rising edges.

// File: rtl/icu_pkg.sv
package icu_pkg;

  localparam int CFG_W = 6;
  localparam int B_GIE = 0;
  localparam int B_ENX = 1;
  localparam int B_ENT = 2;
  localparam int B_POL = 3;
  localparam int B_PX  = 4;
  localparam int B_PT  = 5;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ENTRY = 2'd1,
    PH_RET   = 2'd2
  } icu_phase_e;

  typedef struct packed {
    logic acceptHw;
    logic acceptTrap;
    logic acceptRet;
    logic pushLo;
    logic pushHi;
    logic spDrop;
    logic vecLoad;
    logic popHi;
    logic popFinish;
    logic retiSet;
  } icu_strobe_t;

endpackage

// File: rtl/icu_ctrl.sv
module icu_ctrl
  import icu_pkg::*;
#(
  parameter int ENTRY_CYCLES = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        atBoundary,
  input  logic        retReq,
  input  logic        retSetsGie,
  input  logic        trapPend,
  input  logic        maskReq,
  output icu_strobe_t strobe,
  output logic        seqBusy
);

  localparam int CNT_W = $clog2(ENTRY_CYCLES);
  localparam logic [CNT_W-1:0] LAST_ENTRY = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAST_RET   = CNT_W'(1);

  icu_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic             retIsReti;
  logic             idle;

  always_comb begin
    idle              = (phase == PH_IDLE);
    strobe            = '0;
    strobe.acceptRet  = idle & retReq;
    strobe.acceptTrap = idle & ~retReq & atBoundary & trapPend;
    strobe.acceptHw   = idle & ~retReq & atBoundary & ~trapPend & maskReq;
    strobe.pushLo     = (phase == PH_ENTRY) && (cnt == '0);
    strobe.pushHi     = (phase == PH_ENTRY) && (cnt == CNT_W'(1));
    strobe.spDrop     = (phase == PH_ENTRY) && (cnt == CNT_W'(2));
    strobe.vecLoad    = (phase == PH_ENTRY) && (cnt == LAST_ENTRY);
    strobe.popHi      = (phase == PH_RET) && (cnt == '0);
    strobe.popFinish  = (phase == PH_RET) && (cnt == LAST_RET);
    strobe.retiSet    = strobe.popFinish & retIsReti;
    seqBusy           = ~idle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      retIsReti <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (strobe.acceptRet) begin
            phase     <= PH_RET;
            retIsReti <= retSetsGie;
          end else if (strobe.acceptTrap || strobe.acceptHw) begin
            phase <= PH_ENTRY;
          end
        end
        PH_ENTRY: begin
          if (cnt == LAST_ENTRY) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_RET: begin
          if (cnt == LAST_RET) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/icu_dp.sv
module icu_dp
  import icu_pkg::*;
#(
  parameter int PC_W        = 15,
  parameter int D_W         = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [PC_W-1:0] VECTOR = 15'h00FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  icu_strobe_t       strobe,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic [CFG_W-1:0]  cfgQ,
  input  logic              extPin,
  input  logic              timerEvt,
  input  logic              trapReq,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [D_W-1:0]    spIn,
  input  logic [D_W-1:0]    memRdata,
  output logic              trapPend,
  output logic              maskReq,
  output logic              memWe,
  output logic              memRe,
  output logic [D_W-1:0]    memAddr,
  output logic [D_W-1:0]    memWdata,
  output logic              spWe,
  output logic [D_W-1:0]    spWdata,
  output logic              pcWe,
  output logic [PC_W-1:0]   pcWdata
);

  localparam int HI_W = PC_W - D_W;
  localparam int PAD_W = 2 * D_W - PC_W;
  localparam logic [D_W-1:0] ONE = D_W'(1);
  localparam logic [D_W-1:0] TWO = D_W'(2);

  logic             gie, enX, enT, pol, pendX, pendT;
  logic [SYNC_STAGES:0] syncQ;
  logic             edgeHit;
  logic [PC_W-1:0]  pcLat;
  logic [D_W-1:0]   spLat;
  logic [HI_W-1:0]  hiLat;

  // Pin synchroniser plus one history flop for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], extPin};
  end

  always_comb begin
    edgeHit = pol ? (~syncQ[SYNC_STAGES-1] &  syncQ[SYNC_STAGES])
                  : ( syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gie      <= 1'b0;
      enX      <= 1'b0;
      enT      <= 1'b0;
      pol      <= 1'b0;
      pendX    <= 1'b0;
      pendT    <= 1'b0;
      trapPend <= 1'b0;
    end else begin
      if (strobe.acceptHw)     gie <= 1'b0;
      else if (strobe.retiSet) gie <= 1'b1;
      else if (cfgWe)          gie <= cfgWdata[B_GIE];
      if (cfgWe) begin
        enX <= cfgWdata[B_ENX];
        enT <= cfgWdata[B_ENT];
        pol <= cfgWdata[B_POL];
      end
      pendX <= (cfgWe ? cfgWdata[B_PX] : pendX) | edgeHit;
      pendT <= (cfgWe ? cfgWdata[B_PT] : pendT) | timerEvt;
      if (trapReq)                trapPend <= 1'b1;
      else if (strobe.acceptTrap) trapPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcLat <= '0;
      spLat <= '0;
      hiLat <= '0;
    end else begin
      if (strobe.acceptHw || strobe.acceptTrap) pcLat <= pcIn;
      if (strobe.acceptHw || strobe.acceptTrap || strobe.acceptRet) spLat <= spIn;
      if (strobe.popHi) hiLat <= memRdata[HI_W-1:0];
    end
  end

  always_comb begin
    cfgQ          = '0;
    cfgQ[B_GIE]   = gie;
    cfgQ[B_ENX]   = enX;
    cfgQ[B_ENT]   = enT;
    cfgQ[B_POL]   = pol;
    cfgQ[B_PX]    = pendX;
    cfgQ[B_PT]    = pendT;
    maskReq       = gie & ((enX & pendX) | (enT & pendT));

    memWe    = strobe.pushLo | strobe.pushHi;
    memRe    = strobe.popHi | strobe.popFinish;
    memAddr  = spLat;
    memWdata = pcLat[D_W-1:0];
    if (strobe.pushHi) begin
      memAddr  = spLat - ONE;
      memWdata = {{PAD_W{1'b0}}, pcLat[PC_W-1:D_W]};
    end else if (strobe.popHi) begin
      memAddr  = spLat + ONE;
    end else if (strobe.popFinish) begin
      memAddr  = spLat + TWO;
    end

    spWe    = strobe.spDrop | strobe.popFinish;
    spWdata = strobe.spDrop ? (spLat - TWO) : (spLat + TWO);
    pcWe    = strobe.vecLoad | strobe.popFinish;
    pcWdata = strobe.vecLoad ? VECTOR : {hiLat, memRdata};
  end

endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int PC_W         = 15,
  parameter int D_W          = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 7,
  parameter logic [PC_W-1:0] VECTOR = 15'h00FF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [5:0]       cfgWdata,
  output logic [5:0]       cfgQ,
  input  logic             extPin,
  input  logic             timerEvt,
  input  logic             trapReq,
  input  logic             retReq,
  input  logic             retSetsGie,
  input  logic             atBoundary,
  input  logic [PC_W-1:0]  pcIn,
  input  logic [D_W-1:0]   spIn,
  output logic             memWe,
  output logic             memRe,
  output logic [D_W-1:0]   memAddr,
  output logic [D_W-1:0]   memWdata,
  input  logic [D_W-1:0]   memRdata,
  output logic             spWe,
  output logic [D_W-1:0]   spWdata,
  output logic             pcWe,
  output logic [PC_W-1:0]  pcWdata,
  output logic             seqBusy
);

  icu_strobe_t strobe;
  logic        trapPend;
  logic        maskReq;

  icu_ctrl #(.ENTRY_CYCLES(ENTRY_CYCLES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .atBoundary (atBoundary),
    .retReq     (retReq),
    .retSetsGie (retSetsGie),
    .trapPend   (trapPend),
    .maskReq    (maskReq),
    .strobe     (strobe),
    .seqBusy    (seqBusy)
  );

  icu_dp #(
    .PC_W(PC_W), .D_W(D_W), .SYNC_STAGES(SYNC_STAGES), .VECTOR(VECTOR)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .cfgQ     (cfgQ),
    .extPin   (extPin),
    .timerEvt (timerEvt),
    .trapReq  (trapReq),
    .pcIn     (pcIn),
    .spIn     (spIn),
    .memRdata (memRdata),
    .trapPend (trapPend),
    .maskReq  (maskReq),
    .memWe    (memWe),
    .memRe    (memRe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .spWe     (spWe),
    .spWdata  (spWdata),
    .pcWe     (pcWe),
    .pcWdata  (pcWdata)
  );

endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
  parameter int PC_W         = 15,
  parameter int ENTRY_CYCLES = 7,
  parameter logic [PC_W-1:0] VECTOR = 15'h00FF
) (
  input logic            clk,
  input logic            rstN,
  input logic [5:0]      cfgQ,
  input logic            cfgWe,
  input logic            seqBusy,
  input logic            pcWe,
  input logic [PC_W-1:0] pcWdata,
  input logic            acceptHw,
  input logic            acceptTrap,
  input logic            vecLoad
);

  logic [7:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         runLen <= '0;
    else if (!seqBusy) runLen <= '0;
    else               runLen <= runLen + 8'd1;
  end

  a_r6_entry_length: assert property (@(posedge clk) disable iff (!rstN)
    vecLoad |-> (runLen == 8'(ENTRY_CYCLES - 1)));

  a_r6_vector_load: assert property (@(posedge clk) disable iff (!rstN)
    vecLoad |-> (pcWe && pcWdata == VECTOR));

  a_r9_end_loads_pc: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seqBusy) |-> $past(pcWe));

  a_r7_hw_clears_gie: assert property (@(posedge clk) disable iff (!rstN)
    acceptHw |=> !cfgQ[0]);

  a_r5_hw_needs_gie: assert property (@(posedge clk) disable iff (!rstN)
    acceptHw |-> cfgQ[0]);

  a_r8_trap_keeps_gie: assert property (@(posedge clk) disable iff (!rstN)
    (acceptTrap && !cfgWe) |=> (cfgQ[0] == $past(cfgQ[0])));

  a_r3_ext_pend_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[4] && !cfgWe) |=> cfgQ[4]);

  a_r3_tmr_pend_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[5] && !cfgWe) |=> cfgQ[5]);

endmodule

bind icu_top icu_checker #(
  .PC_W(PC_W), .ENTRY_CYCLES(ENTRY_CYCLES), .VECTOR(VECTOR)
) i_icu_checker (
  .clk        (clk),
  .rstN       (rstN),
  .cfgQ       (cfgQ),
  .cfgWe      (cfgWe),
  .seqBusy    (seqBusy),
  .pcWe       (pcWe),
  .pcWdata    (pcWdata),
  .acceptHw   (strobe.acceptHw),
  .acceptTrap (strobe.acceptTrap),
  .vecLoad    (strobe.vecLoad)
);

// File: tb/test_icu_top.sv
module test_icu_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [5:0]  cfgWdata;
  logic [5:0]  cfgQ;
  logic        extPin, timerEvt, trapReq, retReq, retSetsGie, atBoundary;
  logic [14:0] pcIn;
  logic [7:0]  spIn;
  logic        memWe, memRe, spWe, pcWe, seqBusy;
  logic [7:0]  memAddr, memWdata, memRdata, spWdata;
  logic [14:0] pcWdata;

  int checks = 0;
  int failures = 0;
  logic [7:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  icu_top i_icu_top (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgQ(cfgQ),
    .extPin(extPin), .timerEvt(timerEvt), .trapReq(trapReq), .retReq(retReq),
    .retSetsGie(retSetsGie), .atBoundary(atBoundary), .pcIn(pcIn), .spIn(spIn),
    .memWe(memWe), .memRe(memRe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .spWe(spWe), .spWdata(spWdata), .pcWe(pcWe),
    .pcWdata(pcWdata), .seqBusy(seqBusy)
  );

  always @(posedge clk) if (memWe) mem[memAddr] <= memWdata;
  assign memRdata = mem[memAddr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCfg(input logic [5:0] v);
    cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic edgeExpected(input logic a, input logic b, input logic pol);
    return pol ? (a & ~b) : (~a & b);
  endfunction

  // Called at the sample where seqBusy first reads 1 (entry cycle 0).
  task automatic checkEntry(input logic [14:0] pc, input logic [7:0] sp);
    chk("R6 c0 we", {memWe, memAddr, memWdata}, {1'b1, sp, pc[7:0]});
    step(1);
    chk("R6 c1 we", {memWe, memAddr, memWdata}, {1'b1, sp - 8'd1, 1'b0, pc[14:8]});
    step(1);
    chk("R6 c2 sp", {spWe, spWdata}, {1'b1, sp - 8'd2});
    step(4);
    chk("R6 c6 pc", {seqBusy, pcWe, pcWdata}, {1'b1, 1'b1, 15'h00FF});
    step(1);
    chk("R6 end busy", {31'd0, seqBusy}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rstN = 1'b0; cfgWe = 0; cfgWdata = '0; extPin = 0; timerEvt = 0;
    trapReq = 0; retReq = 0; retSetsGie = 0; atBoundary = 1;
    pcIn = 15'h4A5C; spIn = 8'h6F;
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R1 cfg", {26'd0, cfgQ}, 32'd0);
    chk("R1 strobes", {27'd0, seqBusy, memWe, memRe, spWe, pcWe}, 32'd0);

    // R10 layout round trip (boundary held low so nothing is taken)
    atBoundary = 0;
    writeCfg(6'h3F);
    chk("R10 all ones", {26'd0, cfgQ}, 32'h3F);
    writeCfg(6'h0A);
    chk("R10 enx pol", {26'd0, cfgQ}, 32'h0A);
    writeCfg(6'h00);
    atBoundary = 1;

    // R2 / R4 random edges and timer pulses, global enable off
    begin
      int unsigned seed = 32'd7;
      void'($urandom(seed));
      for (int it = 0; it < 40; it++) begin
        logic p0, p1, pol, t;
        p0 = 1'($urandom); p1 = 1'($urandom);
        pol = 1'($urandom); t = 1'($urandom);
        extPin = p0;
        step(4);
        writeCfg({2'b00, pol, 3'b000});
        extPin = p1; timerEvt = t;
        step(1);
        timerEvt = 0;
        chk("R4 tmr pend", {31'd0, cfgQ[5]}, {31'd0, t});
        step(1);
        chk("R2 not yet", {31'd0, cfgQ[4]}, 32'd0);
        step(1);
        chk("R2 ext pend", {31'd0, cfgQ[4]}, {31'd0, edgeExpected(p0, p1, pol)});
        chk("R2 no entry", {31'd0, seqBusy}, 32'd0);
      end
    end
    extPin = 0;
    step(4);
    writeCfg(6'h00);

    // R3 sticky and event-beats-clear
    timerEvt = 1; step(1); timerEvt = 0;
    step(5);
    chk("R3 sticky", {31'd0, cfgQ[5]}, 32'd1);
    timerEvt = 1; cfgWe = 1; cfgWdata = 6'h00;
    step(1);
    timerEvt = 0; cfgWe = 0;
    chk("R3 event wins", {31'd0, cfgQ[5]}, 32'd1);
    writeCfg(6'h00);
    chk("R3 sw clear", {26'd0, cfgQ}, 32'd0);

    // R5 gating
    writeCfg(6'h02);
    extPin = 1;
    step(5);
    chk("R5 gie off", {30'd0, cfgQ[4], seqBusy}, 32'b10);
    writeCfg(6'h11);
    step(4);
    chk("R5 enable off", {31'd0, seqBusy}, 32'd0);
    atBoundary = 0;
    writeCfg(6'h13);
    step(4);
    chk("R5 no boundary", {31'd0, seqBusy}, 32'd0);
    atBoundary = 1;
    step(1);
    chk("R5 taken", {31'd0, seqBusy}, 32'd1);
    chk("R7 gie cleared pend kept", {30'd0, cfgQ[4], cfgQ[0]}, 32'b10);
    checkEntry(15'h4A5C, 8'h6F);
    writeCfg(6'h02);

    // R9 return with enable re-arm, then plain return
    spIn = 8'h6D; pcIn = 15'h0123;
    retSetsGie = 1; retReq = 1;
    step(1);
    retReq = 0; retSetsGie = 0;
    chk("R9 pop hi", {memRe, memAddr}, {1'b1, 8'h6E});
    step(1);
    chk("R9 pop lo", {memRe, memAddr, pcWe, pcWdata}, {1'b1, 8'h6F, 1'b1, 15'h4A5C});
    chk("R9 sp up", {spWe, spWdata}, {1'b1, 8'h6F});
    step(1);
    chk("R9 reti gie", {30'd0, seqBusy, cfgQ[0]}, 32'b01);
    writeCfg(6'h00);
    retReq = 1;
    step(1);
    retReq = 0;
    step(1);
    chk("R9 plain pc", {pcWe, pcWdata}, {1'b1, 15'h4A5C});
    step(1);
    chk("R9 plain gie", {30'd0, seqBusy, cfgQ[0]}, 32'd0);

    // R8 trap with enable off
    extPin = 0;
    spIn = 8'h6F;
    trapReq = 1; step(1); trapReq = 0;
    chk("R8 latch", {31'd0, seqBusy}, 32'd0);
    step(1);
    chk("R8 taken gie off", {30'd0, seqBusy, cfgQ[0]}, 32'b10);
    checkEntry(15'h0123, 8'h6F);

    // R8 priority over a ready maskable request
    atBoundary = 0;
    writeCfg(6'h12);
    trapReq = 1; step(1); trapReq = 0;
    cfgWe = 1; cfgWdata = 6'h13; atBoundary = 1;
    step(1);
    cfgWe = 0;
    chk("R8 trap keeps gie", {30'd0, seqBusy, cfgQ[0]}, 32'b11);
    step(7);
    chk("R8 gap", {30'd0, seqBusy, cfgQ[0]}, 32'b01);
    step(1);
    chk("R8 then hw", {30'd0, seqBusy, cfgQ[0]}, 32'b10);
    step(7);
    writeCfg(6'h00);
    chk("R8 settled", {31'd0, seqBusy}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule